// File: doc/BRIEF.md
# Sticky Error and Master Control Register

This block is an 8-bit control and status register on a simple host register bus. Its upper four bits collect error events from four sources. One source is a PLL lock detector, two are the DMA read and write overrun detectors, and the last is a watchdog that watches an incoming backplane clock. Once set, an error bit stays set until the host writes a zero to that bit. The block drives a single combined error pin high while any error bit is set.

The lower four bits are control bits. Bit 3 selects whether the block is master of the backplane clocks. Bit 2 enables DMA. Bit 1 enables the stream outputs. Bit 0 is a soft reset that clears the control space while it is set. The soft reset leaves the memories untouched, so the memories only see it as an output level.

The DMA overrun detectors live inside the block. Each one tracks whether the current request has been served. The backplane clock watchdog counts system clock cycles between edges of the synchronised backplane clock. The PLL and the DMA engine themselves are outside the block and appear only as input pulses and strobes.

Top module: `err_ctl_reg`

## Requirements
- R1: After a hardware reset (rst_n low at a clock edge), rd_data reads 8'h00, err_o is low and local_o is 4'b0101.
- R2: A one-cycle pll_unlock pulse sets rd_data[7] at the next clock edge. The bit stays set after the pulse has ended.
- R3: A dma_wr_req pulse arriving while an earlier write request has not yet been acknowledged by dma_wr_done sets rd_data[6] at that clock edge. A request that arrives after the done strobe does not set it.
- R4: Likewise, a dma_rd_req pulse arriving while an earlier read request is still unserved (no dma_rd_done yet) sets rd_data[5]. A request that arrives after dma_rd_done does not set it.
- R5: rd_data[4] is set once the synchronised bp_clk has shown no edge for 4*CYC_PER_US system clock cycles. While bp_clk keeps toggling, the bit stays clear.
- R6: A host write of zero to any of bits 7..4 clears that bit. A write of one leaves it as it was, and never sets a clear bit.
- R7: If an error event arrives in the same cycle as a host write that clears its bit, the bit stays set.
- R8: err_o is high exactly when at least one of rd_data[7:4] is set.
- R9: Host writes to bits 3..1 read back unchanged. They drive bus_master_o (bit 3), dma_en_o (bit 2) and stream_oe_o (bit 1).
- R10: While bit 1 is clear, local_o is held at 4'b0101 (outputs 0 and 2 high, outputs 1 and 3 low). While bit 1 is set, local_o follows local_d.
- R11: A write with bit 0 set clears bits 7..1 at that same edge. Bit 0 then stays set and soft_rst_o is high. Error events and writes to bits 7..1 have no effect until a write clears bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| wr_data | input | 8 | Host write data |
| rd_data | output | 8 | Current register contents |
| pll_unlock | input | 1 | PLL loss-of-lock event pulse |
| dma_wr_req | input | 1 | DMA write request pulse |
| dma_wr_done | input | 1 | DMA write request served |
| dma_rd_req | input | 1 | DMA read request pulse |
| dma_rd_done | input | 1 | DMA read request served |
| bp_clk | input | 1 | Monitored backplane clock, asynchronous |
| local_d | input | 4 | Local output values used when the stream outputs are enabled |
| err_o | output | 1 | Combined error pin |
| bus_master_o | output | 1 | Drive backplane clocks as master |
| dma_en_o | output | 1 | DMA enable |
| stream_oe_o | output | 1 | Stream output enable |
| soft_rst_o | output | 1 | Soft reset level |
| local_o | output | 4 | Local outputs |

## Verification
The register is the only state between the ports, so writes, PLL pulses and DMA request pulses show up in rd_data and err_o one edge after they are driven. The bench drives its inputs on the falling edge and samples on the following falling edge. local_o and the control outputs are combinational from the register and are checked on that same falling edge. The clock watchdog has a slack of a few cycles, caused by the synchroniser and the edge detector. For that reason, its checks sample well inside the quiet window and well past it rather than at the exact limit.

// File: rtl/err_ctl_pkg.sv
// Package: bit positions and fixed values shared by the register and its checker.
// Assumes an 8-bit register with the error bits in the upper nibble.
package err_ctl_pkg;
    localparam int REG_W     = 8;
    localparam int B_PLL     = 7;
    localparam int B_DMAW    = 6;
    localparam int B_DMAR    = 5;
    localparam int B_CLKLOSS = 4;
    localparam int B_MASTER  = 3;
    localparam int B_DMAEN   = 2;
    localparam int B_OE      = 1;
    localparam int B_SRST    = 0;
    localparam int N_ERR     = 4;
    localparam logic [3:0] LOCAL_IDLE = 4'b0101;
endpackage

// File: rtl/err_bp_watchdog.sv
// Module: backplane clock activity watchdog.
// Synchronises an asynchronous clock, detects its edges and raises a timeout
// level once LIMIT system cycles pass with no edge. Assumes clr is synchronous.
module err_bp_watchdog #(
    parameter int LIMIT = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic mon_clk,
    output logic timeout
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM_C = CW'(LIMIT);
    localparam logic [CW-1:0] ONE_C = {{(CW-1){1'b0}}, 1'b1};

    logic [2:0]    sync_q;
    logic [CW-1:0] cnt_q;
    logic          edge_seen;

    // Purpose: bring the monitored clock into the system domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 3'b000;
        else        sync_q <= {sync_q[1:0], mon_clk};
    end

    assign edge_seen = sync_q[2] ^ sync_q[1];

    // Purpose: count quiet cycles, restart on each edge, saturate at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)       cnt_q <= '0;
        else if (edge_seen)      cnt_q <= '0;
        else if (cnt_q != LIM_C) cnt_q <= cnt_q + ONE_C;
    end

    assign timeout = (cnt_q == LIM_C);
endmodule

// File: rtl/err_overrun_det.sv
// Module: request overrun detector.
// Tracks one outstanding request; a new request while one is unserved is an
// overrun. A done strobe in the same cycle as a new request counts as served.
module err_overrun_det (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic req,
    input  logic done,
    output logic overrun
);
    logic pend_q;

    // Purpose: remember whether a request is still waiting for service.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) pend_q <= 1'b0;
        else if (req)      pend_q <= 1'b1;
        else if (done)     pend_q <= 1'b0;
    end

    assign overrun = req && pend_q && !done;
endmodule

// File: rtl/err_status_core.sv
// Module: register storage with sticky error bits and control bits.
// Error bits clear only on a written zero, and a same-cycle event wins. A soft
// reset bit clears bits above it while set. Events arrive ordered high to low.
module err_status_core
    import err_ctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [REG_W-1:0]   wr_data,
    input  logic [N_ERR-1:0]   err_ev,
    output logic [REG_W-1:0]   q
);
    localparam int CTL_W = REG_W - N_ERR;

    logic              srst_eff;
    logic [N_ERR-1:0]  keep_mask;
    logic [REG_W-1:0]  nxt;

    assign srst_eff  = wr_en ? wr_data[B_SRST] : q[B_SRST];
    assign keep_mask = wr_en ? wr_data[REG_W-1:CTL_W] : {N_ERR{1'b1}};

    // Purpose: form the next register value from writes, events and soft reset.
    always_comb begin
        nxt = q;
        for (int i = 0; i < N_ERR; i++) begin
            nxt[CTL_W + i] = (q[CTL_W + i] & keep_mask[i]) | err_ev[i];
        end
        if (wr_en) nxt[CTL_W-1:0] = wr_data[CTL_W-1:0];
        if (srst_eff) nxt[REG_W-1:1] = '0;
        nxt[B_SRST] = srst_eff;
    end

    // Purpose: hold the register, cleared by the hardware reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end
endmodule

// File: rtl/err_ctl_reg.sv
// Module: top of the sticky error / master control register.
// Combines the watchdog, two overrun detectors and the register core, and
// drives the combined error pin, control outputs and idle local output levels.
module err_ctl_reg
    import err_ctl_pkg::*;
#(
    parameter int CYC_PER_US  = 100,
    parameter int TIMEOUT_US  = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [7:0]  wr_data,
    output logic [7:0]  rd_data,
    input  logic        pll_unlock,
    input  logic        dma_wr_req,
    input  logic        dma_wr_done,
    input  logic        dma_rd_req,
    input  logic        dma_rd_done,
    input  logic        bp_clk,
    input  logic [3:0]  local_d,
    output logic        err_o,
    output logic        bus_master_o,
    output logic        dma_en_o,
    output logic        stream_oe_o,
    output logic        soft_rst_o,
    output logic [3:0]  local_o
);
    localparam int LIMIT = TIMEOUT_US * CYC_PER_US;

    logic [REG_W-1:0] q;
    logic [1:0]       dma_req, dma_done, dma_ovr;
    logic             clk_lost;
    logic [N_ERR-1:0] ev;
    logic             srst;

    assign srst     = q[B_SRST];
    assign dma_req  = {dma_wr_req, dma_rd_req};
    assign dma_done = {dma_wr_done, dma_rd_done};

    // Two identical overrun detectors: index 1 write, index 0 read.
    for (genvar g = 0; g < 2; g++) begin : g_ovr
        err_overrun_det u_det (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (srst),
            .req     (dma_req[g]),
            .done    (dma_done[g]),
            .overrun (dma_ovr[g])
        );
    end

    err_bp_watchdog #(.LIMIT(LIMIT)) u_wdog (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (srst),
        .mon_clk (bp_clk),
        .timeout (clk_lost)
    );

    assign ev = {pll_unlock, dma_ovr[1], dma_ovr[0], clk_lost};

    err_status_core u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .err_ev  (ev),
        .q       (q)
    );

    assign rd_data      = q;
    assign err_o        = |q[REG_W-1:REG_W-N_ERR];
    assign bus_master_o = q[B_MASTER];
    assign dma_en_o     = q[B_DMAEN];
    assign stream_oe_o  = q[B_OE];
    assign soft_rst_o   = srst;
    assign local_o      = q[B_OE] ? local_d : LOCAL_IDLE;
endmodule

// File: rtl/err_ctl_checker.sv
// Module: property checker for err_ctl_reg, attached by bind.
// Observes only top-level ports.
module err_ctl_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic       pll_unlock,
    input logic       err_o,
    input logic       stream_oe_o,
    input logic       soft_rst_o,
    input logic [3:0] local_o
);
    logic srst_next;
    assign srst_next = wr_en ? wr_data[0] : soft_rst_o;

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (rd_data == 8'h00));

    a_r2_pll_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_unlock && !srst_next) |=> rd_data[7]);

    a_r6_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[7] && !srst_next && !(wr_en && !wr_data[7])) |=> rd_data[7]);

    a_r9_ctl_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[0]) |=> (rd_data[3:1] == $past(wr_data[3:1])));

    a_r10_idle_levels: assert property (@(posedge clk) disable iff (!rst_n)
        !stream_oe_o |-> (local_o == 4'b0101));

    a_r11_srst_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_o |-> ((rd_data[7:1] == 7'd0) && !err_o));
endmodule

bind err_ctl_reg err_ctl_checker chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .rd_data     (rd_data),
    .pll_unlock  (pll_unlock),
    .err_o       (err_o),
    .stream_oe_o (stream_oe_o),
    .soft_rst_o  (soft_rst_o),
    .local_o     (local_o)
);

// File: tb/err_ctl_reg_tb_top.sv
// Directed bench for err_ctl_reg: one task per scenario, each self-checking.
module err_ctl_reg_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       pll_unlock = 1'b0;
    logic       dma_wr_req = 1'b0, dma_wr_done = 1'b0;
    logic       dma_rd_req = 1'b0, dma_rd_done = 1'b0;
    logic       bp_clk = 1'b0;
    logic       bp_run = 1'b1;
    logic [3:0] local_d = 4'b1010;
    logic       err_o, bus_master_o, dma_en_o, stream_oe_o, soft_rst_o;
    logic [3:0] local_o;

    int n_chk = 0;
    int n_fail = 0;

    localparam int LIMIT = 400;

    always #5 clk = ~clk;

    initial forever begin
        #37;
        if (bp_run) bp_clk = ~bp_clk;
    end

    err_ctl_reg dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .pll_unlock(pll_unlock),
        .dma_wr_req(dma_wr_req), .dma_wr_done(dma_wr_done),
        .dma_rd_req(dma_rd_req), .dma_rd_done(dma_rd_done),
        .bp_clk(bp_clk), .local_d(local_d), .err_o(err_o),
        .bus_master_o(bus_master_o), .dma_en_o(dma_en_o),
        .stream_oe_o(stream_oe_o), .soft_rst_o(soft_rst_o), .local_o(local_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic host_wr(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        check("R1 rd_data", rd_data, 8'h00);
        check("R1 err_o", err_o, 1'b0);
        check("R1 local_o", local_o, 4'b0101);
    endtask

    task automatic t_pll();
        pll_unlock = 1'b1; tick(); pll_unlock = 1'b0;
        check("R2 bit7 set", rd_data, 8'h80);
        check("R8 err_o high", err_o, 1'b1);
        tick(); tick();
        check("R2 bit7 held", rd_data[7], 1'b1);
        host_wr(8'hF0);
        check("R6 write one keeps", rd_data, 8'h80);
        pll_unlock = 1'b1; wr_en = 1'b1; wr_data = 8'h00; tick();
        pll_unlock = 1'b0; wr_en = 1'b0;
        check("R7 event wins over clear", rd_data[7], 1'b1);
        host_wr(8'h70);
        check("R6 write zero clears", rd_data, 8'h00);
        check("R8 err_o low", err_o, 1'b0);
    endtask

    task automatic t_dma();
        dma_wr_req = 1'b1; tick(); dma_wr_req = 1'b0;
        dma_wr_done = 1'b1; tick(); dma_wr_done = 1'b0;
        dma_wr_req = 1'b1; tick(); dma_wr_req = 1'b0;
        check("R3 served no overrun", rd_data[6], 1'b0);
        dma_wr_req = 1'b1; tick(); dma_wr_req = 1'b0;
        check("R3 write overrun", rd_data, 8'h40);
        dma_rd_req = 1'b1; tick(); dma_rd_req = 1'b0;
        dma_rd_done = 1'b1; tick(); dma_rd_done = 1'b0;
        dma_rd_req = 1'b1; tick(); dma_rd_req = 1'b0;
        check("R4 served no overrun", rd_data[5], 1'b0);
        dma_rd_req = 1'b1; tick(); dma_rd_req = 1'b0;
        check("R4 read overrun", rd_data, 8'h60);
        host_wr(8'h00);
        check("R6 clear both", rd_data, 8'h00);
        dma_wr_done = 1'b1; dma_rd_done = 1'b1; tick();
        dma_wr_done = 1'b0; dma_rd_done = 1'b0;
    endtask

    task automatic t_ctl();
        host_wr(8'h0C);
        check("R9 readback", rd_data, 8'h0C);
        check("R9 outputs", {bus_master_o, dma_en_o, stream_oe_o}, 3'b110);
        check("R10 idle levels", local_o, 4'b0101);
        host_wr(8'h0A);
        check("R9 oe out", {bus_master_o, dma_en_o, stream_oe_o}, 3'b101);
        local_d = 4'b1001;
        @(posedge clk); @(negedge clk);
        check("R10 pass through", local_o, 4'b1001);
    endtask

    task automatic t_srst();
        pll_unlock = 1'b1; tick(); pll_unlock = 1'b0;
        host_wr(8'hFF);
        check("R11 cleared on set", rd_data, 8'h01);
        check("R11 soft_rst_o", soft_rst_o, 1'b1);
        check("R11 err_o low", err_o, 1'b0);
        pll_unlock = 1'b1; tick(); pll_unlock = 1'b0;
        check("R11 event ignored", rd_data, 8'h01);
        check("R11 local idle", local_o, 4'b0101);
        host_wr(8'h02);
        check("R11 release", rd_data, 8'h02);
        check("R11 soft_rst_o low", soft_rst_o, 1'b0);
        host_wr(8'h00);
    endtask

    task automatic t_wdog();
        for (int i = 0; i < 60; i++) tick();
        check("R5 alive clear", rd_data[4], 1'b0);
        bp_run = 1'b0;
        for (int i = 0; i < LIMIT - 20; i++) tick();
        check("R5 not yet timed out", rd_data[4], 1'b0);
        for (int i = 0; i < 40; i++) tick();
        check("R5 timed out", rd_data[4], 1'b1);
        check("R8 err_o from bit4", err_o, 1'b1);
        bp_run = 1'b1;
        for (int i = 0; i < 10; i++) tick();
        host_wr(8'h00);
        for (int i = 0; i < 50; i++) tick();
        check("R5 stays clear", rd_data[4], 1'b0);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_pll();
        t_dma();
        t_ctl();
        t_srst();
        t_wdog();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule